// File: doc/BRIEF.md
# Modem GPIO Control Register Bank

This block is the modem-side register bank of an audio codec's control section. A host reaches it through an index/data access port. The port carries a write strobe, a read strobe, a 7-bit register index and 16-bit write data, and it returns 16-bit read data one cycle after a read. The bank holds three words:

- a read-only identity word that reflects two strap pins;
- a status/control word that powers the general-purpose pin section down or brings it up;
- a direction word with one bit per pin for five general-purpose pins.

From this state the bank drives a per-pin output enable. It also drives a valid flag for the inbound status slot of the serial link, and a one-cycle soft-reset pulse for the modem register range. A write of any value to the identity index returns the modem registers to their defaults. Registers outside the modem range are not touched.

Serial-port enable inputs can take over pins. One enable claims pins 1 and 0 together. Each of three further enables claims one of pins 2, 3 and 4. A claimed pin's direction bit reads zero, keeps its stored value across writes, and its output enable stays off.

Top module: `modem_gpio_regs`

## Requirements
- R1: A read of index 3Ch returns the two strap pins in bits 15:14 and zero in bits 13:0 (strap 00 means primary, anything else secondary). Read data appears on the cycle after the read strobe and holds between reads.
- R2: A write of any data to index 3Ch raises modemSoftRst for exactly the one following cycle. It returns the status word to 0100h and the direction word to 001Fh, so all five pins become inputs.
- R3: The status word at index 3Eh reads 0100h after cold reset. Bit 8 is the writable powerdown bit, bit 0 is the read-only ready flag, and every other bit reads zero whatever is written.
- R4: From the cycle after a write that sets bit 8 of index 3Eh, every pinOe bit is 0 and slotValid is 0.
- R5: After a write that clears the powerdown bit, the ready flag and slotValid stay 0 in the first following cycle and become 1 from the second. slotValid always equals the ready flag.
- R6: The direction word at index 4Ch stores write-data bits 4:0, where 1 means input and 0 means output. It reads 001Fh after cold reset, and bits 15:5 always read zero.
- R7: serClaimPair claims pins 1:0. serClaimHigh[k] claims pin k+2. A claimed pin's direction bit reads 0, its stored bit is left unchanged by writes (visible again once the claim drops), and its pinOe is 0.
- R8: pinOe[i] is 1 exactly when direction bit i is 0, the powerdown bit is clear and pin i is unclaimed. It follows a claim input in the same cycle.
- R9: Reads of any index other than 3Ch, 3Eh and 4Ch return 0000h. Writes to them change no register.
- R10: While and after cold reset, rdData is 0000h, pinOe is 0, slotValid is 0 and modemSoftRst is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| regIdx | input | 7 | Register index |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid the cycle after rdEn |
| strapId | input | 2 | Configuration strap pins |
| serClaimPair | input | 1 | Serial-port enable claiming pins 1:0 |
| serClaimHigh | input | 3 | Serial-port enables claiming pins 2, 3, 4 |
| pinOe | output | 5 | Per-pin output enable |
| slotValid | output | 1 | Inbound status slot valid flag |
| modemSoftRst | output | 1 | One-cycle modem register reset pulse |

## Verification
The bound checker covers the rules that hold on every cycle:

- a claimed pin never drives;
- a powerdown write silences all output enables and slotValid on the next cycle;
- slotValid only rises once powerdown has been clear for a cycle;
- a write to the identity index always yields the reset pulse;
- identity and direction reads keep their zero fields.

Only the bench scenarios can show stored history:

- that a claimed direction bit survives writes and reappears when the claim drops;
- that a soft reset restores defaults while strap reads stay live;
- that writes to unimplemented indices leave the three words unchanged.

// File: rtl/modem_gpio_pkg.sv
package modem_gpio_pkg;

  localparam int IDX_W     = 7;
  localparam int DATA_W    = 16;
  localparam int STRAP_W   = 2;
  localparam int PWR_BIT   = 8;
  localparam int RDY_BIT   = 0;

  localparam logic [IDX_W-1:0] IDX_IDENT  = 7'h3C;
  localparam logic [IDX_W-1:0] IDX_STATUS = 7'h3E;
  localparam logic [IDX_W-1:0] IDX_DIR    = 7'h4C;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_IDENT  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_DIR    = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   softRst;
    logic   wrStatus;
    logic   wrDir;
    logic   rdStrobe;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/modem_gpio_ctrl.sv
module modem_gpio_ctrl
  import modem_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  output ctrlStrobe_t      strobe,
  output logic             softRstPulse
);

  logic hitIdent;
  logic hitStatus;
  logic hitDir;

  always_comb begin
    hitIdent  = (regIdx == IDX_IDENT);
    hitStatus = (regIdx == IDX_STATUS);
    hitDir    = (regIdx == IDX_DIR);
  end

  always_comb begin
    strobe          = '0;
    strobe.softRst  = wrEn && hitIdent;
    strobe.wrStatus = wrEn && hitStatus;
    strobe.wrDir    = wrEn && hitDir;
    strobe.rdStrobe = rdEn;
    if (hitIdent)       strobe.rdSel = SEL_IDENT;
    else if (hitStatus) strobe.rdSel = SEL_STATUS;
    else if (hitDir)    strobe.rdSel = SEL_DIR;
    else                strobe.rdSel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) softRstPulse <= 1'b0;
    else       softRstPulse <= strobe.softRst;
  end

endmodule

// File: rtl/modem_gpio_dp.sv
module modem_gpio_dp
  import modem_gpio_pkg::*;
#(
  parameter int PIN_COUNT = 5,
  parameter int PAIR_PINS = 2,
  localparam int HIGH_W   = PIN_COUNT - PAIR_PINS
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [STRAP_W-1:0]  strapId,
  input  logic                serClaimPair,
  input  logic [HIGH_W-1:0]   serClaimHigh,
  output logic [DATA_W-1:0]   rdData,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                slotValid,
  output logic                pwrDown
);

  localparam logic [PIN_COUNT-1:0] DIR_RESET = '1;

  logic [PIN_COUNT-1:0] claimMask;
  logic [PIN_COUNT-1:0] dirQ;
  logic                 pwrDownQ;
  logic                 readyQ;
  logic                 gpioReady;
  logic [DATA_W-1:0]    identWord;
  logic [DATA_W-1:0]    statusWord;
  logic [DATA_W-1:0]    dirWord;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_claim
    if (p < PAIR_PINS) begin : g_pair
      assign claimMask[p] = serClaimPair;
    end else begin : g_single
      assign claimMask[p] = serClaimHigh[p-PAIR_PINS];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrDownQ <= 1'b1;
    end else if (strobe.softRst) begin
      pwrDownQ <= 1'b1;
    end else if (strobe.wrStatus) begin
      pwrDownQ <= wrData[PWR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               readyQ <= 1'b0;
    else if (strobe.softRst) readyQ <= 1'b0;
    else                     readyQ <= !pwrDownQ;
  end

  assign gpioReady = readyQ && !pwrDownQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= DIR_RESET;
    end else if (strobe.softRst) begin
      dirQ <= DIR_RESET;
    end else if (strobe.wrDir) begin
      dirQ <= (dirQ & claimMask) | (wrData[PIN_COUNT-1:0] & ~claimMask);
    end
  end

  always_comb begin
    identWord = '0;
    identWord[DATA_W-1 -: STRAP_W] = strapId;
    statusWord = '0;
    statusWord[PWR_BIT] = pwrDownQ;
    statusWord[RDY_BIT] = gpioReady;
    dirWord = '0;
    dirWord[PIN_COUNT-1:0] = dirQ & ~claimMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdStrobe) begin
      case (strobe.rdSel)
        SEL_IDENT:  rdData <= identWord;
        SEL_STATUS: rdData <= statusWord;
        SEL_DIR:    rdData <= dirWord;
        default:    rdData <= '0;
      endcase
    end
  end

  assign pinOe     = ~dirQ & ~claimMask & {PIN_COUNT{!pwrDownQ}};
  assign slotValid = gpioReady;
  assign pwrDown   = pwrDownQ;

endmodule

// File: rtl/modem_gpio_regs.sv
module modem_gpio_regs
  import modem_gpio_pkg::*;
#(
  parameter int PIN_COUNT = 5,
  parameter int PAIR_PINS = 2,
  localparam int HIGH_W   = PIN_COUNT - PAIR_PINS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [STRAP_W-1:0]   strapId,
  input  logic                 serClaimPair,
  input  logic [HIGH_W-1:0]    serClaimHigh,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 slotValid,
  output logic                 modemSoftRst
);

  ctrlStrobe_t strobe;
  logic        pwrDown;

  modem_gpio_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .rdEn         (rdEn),
    .regIdx       (regIdx),
    .strobe       (strobe),
    .softRstPulse (modemSoftRst)
  );

  modem_gpio_dp #(
    .PIN_COUNT (PIN_COUNT),
    .PAIR_PINS (PAIR_PINS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrData       (wrData),
    .strapId      (strapId),
    .serClaimPair (serClaimPair),
    .serClaimHigh (serClaimHigh),
    .rdData       (rdData),
    .pinOe        (pinOe),
    .slotValid    (slotValid),
    .pwrDown      (pwrDown)
  );

endmodule

// File: rtl/modem_gpio_chk.sv
module modem_gpio_chk
  import modem_gpio_pkg::*;
#(
  parameter int PIN_COUNT = 5,
  parameter int PAIR_PINS = 2,
  localparam int HIGH_W   = PIN_COUNT - PAIR_PINS
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [IDX_W-1:0]     regIdx,
  input logic                 wrPwrBit,
  input logic [DATA_W-1:0]    rdData,
  input logic [STRAP_W-1:0]   strapId,
  input logic                 serClaimPair,
  input logic [HIGH_W-1:0]    serClaimHigh,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 slotValid,
  input logic                 modemSoftRst,
  input logic                 pwrDown
);

  logic [PIN_COUNT-1:0] claimed;
  assign claimed = {serClaimHigh, {PAIR_PINS{serClaimPair}}};

  // R7
  claim_silences_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe & claimed) == '0);

  // R4
  powerdown_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regIdx == IDX_STATUS && wrPwrBit) |=> (pinOe == '0 && !slotValid));

  // R5
  ready_after_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotValid) |-> $past(!pwrDown));

  // R2
  soft_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regIdx == IDX_IDENT) |=> modemSoftRst);

  // R1
  ident_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == IDX_IDENT) |=>
      (rdData[DATA_W-1 -: STRAP_W] == $past(strapId) && rdData[DATA_W-STRAP_W-1:0] == '0));

  // R6
  dir_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == IDX_DIR) |=> (rdData[DATA_W-1:PIN_COUNT] == '0));

endmodule

bind modem_gpio_regs modem_gpio_chk #(
  .PIN_COUNT (PIN_COUNT),
  .PAIR_PINS (PAIR_PINS)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .rdEn         (rdEn),
  .regIdx       (regIdx),
  .wrPwrBit     (wrData[modem_gpio_pkg::PWR_BIT]),
  .rdData       (rdData),
  .strapId      (strapId),
  .serClaimPair (serClaimPair),
  .serClaimHigh (serClaimHigh),
  .pinOe        (pinOe),
  .slotValid    (slotValid),
  .modemSoftRst (modemSoftRst),
  .pwrDown      (pwrDown)
);

// File: tb/tb_modem_gpio_regs.sv
`timescale 1ns/1ps
module tb_modem_gpio_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [6:0]  regIdx = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0]  strapId = 2'b10;
  logic        serClaimPair = 1'b0;
  logic [2:0]  serClaimHigh = '0;
  logic [4:0]  pinOe;
  logic        slotValid;
  logic        modemSoftRst;

  int nChecks = 0;
  int nErrors = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  modem_gpio_regs dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .regIdx(regIdx),
    .wrData(wrData), .rdData(rdData), .strapId(strapId),
    .serClaimPair(serClaimPair), .serClaimHigh(serClaimHigh),
    .pinOe(pinOe), .slotValid(slotValid), .modemSoftRst(modemSoftRst)
  );

  typedef struct packed {
    logic        isWr;
    logic [6:0]  idx;
    logic [15:0] data;
    logic [15:0] expd;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 7'h3C, 16'h0000, 16'h8000, 4'd1},  // R1 secondary strap
    '{1'b0, 7'h3E, 16'h0000, 16'h0100, 4'd3},  // R3 status default
    '{1'b0, 7'h4C, 16'h0000, 16'h001F, 4'd6},  // R6 direction default
    '{1'b1, 7'h4C, 16'hFFEA, 16'h0000, 4'd6},
    '{1'b0, 7'h4C, 16'h0000, 16'h000A, 4'd6},  // R6 stored low bits only
    '{1'b1, 7'h3E, 16'hFEFF, 16'h0000, 4'd3},
    '{1'b0, 7'h3E, 16'h0000, 16'h0000, 4'd5},  // R5 ready not yet up
    '{1'b0, 7'h3E, 16'h0000, 16'h0001, 4'd5},  // R5 ready up, R3 others zero
    '{1'b1, 7'h40, 16'hFFFF, 16'h0000, 4'd9},
    '{1'b0, 7'h40, 16'h0000, 16'h0000, 4'd9},  // R9 unimplemented reads zero
    '{1'b0, 7'h3E, 16'h0000, 16'h0001, 4'd9},  // R9 write ignored
    '{1'b1, 7'h3E, 16'h0100, 16'h0000, 4'd3},
    '{1'b0, 7'h3E, 16'h0000, 16'h0100, 4'd3},  // R3 powerdown readback
    '{1'b1, 7'h3C, 16'h1234, 16'h0000, 4'd2},
    '{1'b0, 7'h4C, 16'h0000, 16'h001F, 4'd2},  // R2 direction restored
    '{1'b0, 7'h3C, 16'h0000, 16'h8000, 4'd2}   // R2 ident unaffected
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expd);
    nChecks++;
    if (act !== expd) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expd);
    end
  endtask

  task automatic doWrite(input logic [6:0] idx, input logic [15:0] data);
    regIdx = idx; wrData = data; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] idx, output logic [15:0] data);
    regIdx = idx; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    data = rdData;
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 rdData in reset", rdData, 16'h0000);
    check("R10 pinOe in reset", {11'b0, pinOe}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 slotValid after reset", {15'b0, slotValid}, 16'h0000);
    check("R10 softRst after reset", {15'b0, modemSoftRst}, 16'h0000);
    check("R10 pinOe after reset", {11'b0, pinOe}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) begin
        doWrite(VECS[i].idx, VECS[i].data);
      end else begin
        doRead(VECS[i].idx, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].expd);
      end
    end

    // R2 pulse timing
    doWrite(7'h3C, 16'h0000);
    check("R2 pulse first cycle", {15'b0, modemSoftRst}, 16'h0001);
    @(negedge clk);
    check("R2 pulse ends", {15'b0, modemSoftRst}, 16'h0000);

    // R8 outputs with direction 0 and powerdown clear
    doWrite(7'h4C, 16'h0000);
    check("R8 powered down still off", {11'b0, pinOe}, 16'h0000);
    doWrite(7'h3E, 16'h0000);
    check("R8 all outputs on", {11'b0, pinOe}, 16'h001F);
    check("R5 slotValid first cycle low", {15'b0, slotValid}, 16'h0000);
    @(negedge clk);
    check("R5 slotValid second cycle high", {15'b0, slotValid}, 16'h0001);

    // R7 claims
    serClaimPair = 1'b1; serClaimHigh = 3'b100;
    #1;
    check("R7 claimed pins off", {11'b0, pinOe}, 16'h000C);
    doWrite(7'h4C, 16'h001F);
    check("R7 pinOe after write", {11'b0, pinOe}, 16'h0000);
    doRead(7'h4C, rd);
    check("R7 claimed bits read zero", rd, 16'h000C);
    serClaimPair = 1'b0; serClaimHigh = 3'b000;
    doRead(7'h4C, rd);
    check("R7 stored bits kept", rd, 16'h000C);
    check("R8 released pins drive", {11'b0, pinOe}, 16'h0013);

    // R9 write outside range
    doWrite(7'h50, 16'hFFFF);
    doRead(7'h4C, rd);
    check("R9 direction unchanged", rd, 16'h000C);

    // R4 powerdown
    doWrite(7'h3E, 16'h0100);
    check("R4 pinOe off", {11'b0, pinOe}, 16'h0000);
    check("R4 slotValid off", {15'b0, slotValid}, 16'h0000);

    // R1 strap values
    strapId = 2'b00;
    doRead(7'h3C, rd);
    check("R1 primary", rd, 16'h0000);
    strapId = 2'b11;
    doRead(7'h3C, rd);
    check("R1 secondary 11", rd, 16'hC000);
    @(negedge clk);
    check("R1 read data holds", rdData, 16'hC000);

    finishRun();
  end

endmodule